// File: doc/BRIEF.md
# Card Command Path Engine

This block serialises one command frame onto the single-wire command line of a memory-card bus and, when asked to, collects the card's reply. Software first loads a 32-bit argument, then writes a control word that carries the 6-bit command index and the mode bits. The engine builds a 48-bit frame with a CRC7 over its first 40 bits and shifts it out most significant bit first. It then returns to idle, or it listens for a 48-bit or 136-bit reply.

Every step advances only on a card-bit strobe, `card_tick_i`, which an external clock divider supplies. A captured reply lands in four 32-bit response words. The outcome is reported in four sticky status flags: sent, reply ended, reply CRC failed, and reply timed out. Software clears these flags by writing ones to the clear port. Writing a control word with the enable bit low abandons whatever the engine is doing.

Top module: `cmd_path`

## Requirements
- R1: After reset the engine is idle, the line is released (`cmd_oe_o`=0, `cmd_o`=1), all status flags are 0 and all response words are 0.
- R2: A control write with enable set and hold clear sends the frame {0, 1, index[5:0], argument[31:0], CRC7, 1}, most significant bit first, one bit per strobe over 48 strobes, with `cmd_oe_o` high. The CRC7 uses the generator x^7+x^3+1 over the first 40 frame bits. The argument is the value last written with `arg_we_i`.
- R3: With the reply bit clear, the strobe after the last frame bit releases the line and sets status bit 0 (sent). The engine then goes idle.
- R4: A short reply is 48 bits: start 0, transmission 0, 6-bit index, 32-bit payload, CRC7, end bit. When its CRC7 over the first 40 received bits matches, status bit 1 (reply end) sets. Word 0 takes the payload and words 1 to 3 become 0.
- R5: A short reply whose received CRC7 differs sets status bit 2 (CRC fail) and leaves status bit 1 clear. The words are still loaded as in R4.
- R6: With the long bit also set, the reply is 136 bits. Words 3..0 take received frame bits 127..1, and bit 0 of word 0 reads 0. No CRC is checked, and status bit 1 sets.
- R7: If the line stays high for 64 consecutive strobes while a reply is awaited, status bit 3 (timeout) sets and the engine goes idle. A start bit seen on the 64th strobe is accepted.
- R8: A control write with enable (bit 9) clear stops any command at once. The engine goes idle, the line is released, and no status flag is set.
- R9: Control bits are: index in [5:0], reply expected in [6], long reply in [7], hold in [8], enable in [9]. With enable and hold both set, the engine stays busy without driving the line until the next control write.
- R10: A write on the clear port clears each status flag whose bit is 1 and leaves the others. Writing 0xFFF clears them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| card_tick_i | input | 1 | one-cycle strobe per card bit time |
| arg_we_i | input | 1 | argument register write enable |
| arg_i | input | 32 | argument value |
| ctrl_we_i | input | 1 | control word write enable |
| ctrl_i | input | 10 | control word (index, reply, long, hold, enable) |
| clr_we_i | input | 1 | status clear write enable |
| clr_i | input | 12 | write-one-to-clear mask |
| cmd_i | input | 1 | command line as seen from the card |
| cmd_o | output | 1 | command line drive value |
| cmd_oe_o | output | 1 | command line drive enable |
| busy_o | output | 1 | engine is not idle |
| status_o | output | 4 | sticky flags: sent, reply end, CRC fail, timeout |
| rsp0_o | output | 32 | response word 0 |
| rsp1_o | output | 32 | response word 1 |
| rsp2_o | output | 32 | response word 2 |
| rsp3_o | output | 32 | response word 3 |

## Verification
The bench builds the engine with its default 64-strobe reply window and 32-bit words, and it strobes one card bit every four system clocks. At this size a card that waits 63 idle bits before answering, and one that waits 64, are both cheap to model, so the exact edge of the timeout window is tested directly. A full 136-bit long reply also fits easily into the run. The card model derives its own CRC7, so it can corrupt a short reply's CRC to show the failure flag. It also sends a long reply whose internal check field is arbitrary, to show that no CRC check is made on that reply.

// File: rtl/cmd_path_pkg.sv
package cmd_path_pkg;
  localparam int OPC_W    = 6;
  localparam int ARG_W    = 32;
  localparam int FRAME_W  = 48;
  localparam int SHORT_W  = 48;
  localparam int LONG_W   = 136;
  localparam int CRC_SPAN = 40;
  localparam int NSTAT    = 4;

  // control word bit positions
  localparam int C_RSP  = 6;
  localparam int C_LONG = 7;
  localparam int C_HOLD = 8;
  localparam int C_EN   = 9;
  localparam int CTRL_W = 10;

  // status bit positions
  localparam int ST_SENT = 0;
  localparam int ST_REND = 1;
  localparam int ST_CRC  = 2;
  localparam int ST_TMO  = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_TX, S_TX_END, S_RX_WAIT, S_RX
  } seq_e;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction

  function automatic logic [6:0] crc7_span(input logic [CRC_SPAN-1:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = CRC_SPAN - 1; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/cmd_crc7_ser.sv
module cmd_crc7_ser
  import cmd_path_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic [6:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (en_i)    crc_q <= crc7_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;

  p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_o == 7'd0));
endmodule

// File: rtl/cmd_status_regs.sv
module cmd_status_regs #(
  parameter int N     = 4,
  parameter int CLR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     set_i,
  input  logic             clr_we_i,
  input  logic [CLR_W-1:0] clr_i,
  output logic [N-1:0]     status_o
);
  logic [N-1:0] status_q;
  logic [N-1:0] clr_mask;
  logic [N-1:0] keep;
  logic         clr_unused;

  assign clr_mask   = clr_we_i ? clr_i[N-1:0] : '0;
  assign clr_unused = ^clr_i[CLR_W-1:N];
  assign keep       = status_q & ~clr_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= keep | set_i;  // set beats clear
  end

  assign status_o = status_q;

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|keep) |=> ((status_o & $past(keep)) == $past(keep)));
  p_set_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));
  p_one_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_i));
endmodule

// File: rtl/cmd_rsp_capture.sv
module cmd_rsp_capture #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            shift_i,
  input  logic                            bit_i,
  input  logic                            ld_short_i,
  input  logic                            ld_long_i,
  output logic [6:0]                      crc_rx_o,
  output logic [N_WORDS-1:0][WORD_W-1:0]  words_o
);
  localparam int RSP_BITS = WORD_W * N_WORDS;
  localparam int PAY_LSB  = 8;

  logic [RSP_BITS-1:0] sh_q;
  logic [RSP_BITS-1:0] sh_nx;
  logic [1:0]          sh_unused;

  assign sh_nx     = {sh_q[RSP_BITS-2:0], bit_i};
  assign crc_rx_o  = sh_nx[7:1];
  assign sh_unused = {sh_nx[0], sh_q[RSP_BITS-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= sh_nx;
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] long_val;
    logic [WORD_W-1:0] short_val;
    if (w == 0) begin : g_low
      assign long_val  = {sh_nx[WORD_W-1:1], 1'b0};
      assign short_val = sh_nx[PAY_LSB +: WORD_W];
    end else begin : g_high
      assign long_val  = sh_nx[w*WORD_W +: WORD_W];
      assign short_val = '0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         words_o[w] <= '0;
      else if (ld_long_i)  words_o[w] <= long_val;
      else if (ld_short_i) words_o[w] <= short_val;
    end
  end

  p_short_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_short_i && !ld_long_i) |=> (words_o[N_WORDS-1:1] == '0));
  p_long_lsb_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_long_i |=> !words_o[0][0]);
endmodule

// File: rtl/cmd_path.sv
module cmd_path
  import cmd_path_pkg::*;
#(
  parameter int TMO_TICKS = 64,
  parameter int CLR_W     = 12,
  parameter int WORD_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_tick_i,
  input  logic              arg_we_i,
  input  logic [ARG_W-1:0]  arg_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              clr_we_i,
  input  logic [CLR_W-1:0]  clr_i,
  input  logic              cmd_i,
  output logic              cmd_o,
  output logic              cmd_oe_o,
  output logic              busy_o,
  output logic [NSTAT-1:0]  status_o,
  output logic [WORD_W-1:0] rsp0_o,
  output logic [WORD_W-1:0] rsp1_o,
  output logic [WORD_W-1:0] rsp2_o,
  output logic [WORD_W-1:0] rsp3_o
);
  localparam int N_WORDS = 4;
  localparam int CNT_W   = $clog2(LONG_W);
  localparam int TMO_W   = $clog2(TMO_TICKS);

  seq_e                st_q;
  logic [ARG_W-1:0]    arg_q;
  logic [FRAME_W-1:0]  frame_q;
  logic                rsp_q, long_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [TMO_W-1:0]    tmo_q;
  logic                cmd_q, oe_q;

  logic [NSTAT-1:0]    ev_set;
  logic                crc_clr, crc_en;
  logic [6:0]          crc_calc, crc_rx;
  logic                cap_shift, ld_s, ld_l;
  logic                rx_last;
  logic [N_WORDS-1:0][WORD_W-1:0] words;
  logic [FRAME_W-1:0]  new_frame;

  assign new_frame = {2'b01, ctrl_i[OPC_W-1:0], arg_q,
                      crc7_span({2'b01, ctrl_i[OPC_W-1:0], arg_q}), 1'b1};
  assign rx_last = long_q ? (cnt_q == CNT_W'(LONG_W - 1))
                          : (cnt_q == CNT_W'(SHORT_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       arg_q <= '0;
    else if (arg_we_i) arg_q <= arg_i;
  end

  always_comb begin
    ev_set    = '0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    cap_shift = 1'b0;
    ld_s      = 1'b0;
    ld_l      = 1'b0;
    if (!ctrl_we_i && card_tick_i) begin
      unique case (st_q)
        S_TX_END: begin
          crc_clr = 1'b1;
          if (!rsp_q) ev_set[ST_SENT] = 1'b1;
        end
        S_RX_WAIT: begin
          if (!cmd_i) begin
            crc_en    = 1'b1;
            cap_shift = 1'b1;
          end else if (tmo_q == TMO_W'(TMO_TICKS - 1)) begin
            ev_set[ST_TMO] = 1'b1;
          end
        end
        S_RX: begin
          cap_shift = 1'b1;
          crc_en    = (cnt_q < CNT_W'(CRC_SPAN));
          if (rx_last) begin
            if (long_q) begin
              ld_l = 1'b1;
              ev_set[ST_REND] = 1'b1;
            end else begin
              ld_s = 1'b1;
              if (crc_calc == crc_rx) ev_set[ST_REND] = 1'b1;
              else                    ev_set[ST_CRC]  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      frame_q <= '0;
      rsp_q   <= 1'b0;
      long_q  <= 1'b0;
      cnt_q   <= '0;
      tmo_q   <= '0;
      cmd_q   <= 1'b1;
      oe_q    <= 1'b0;
    end else if (ctrl_we_i) begin
      rsp_q   <= ctrl_i[C_RSP];
      long_q  <= ctrl_i[C_RSP] & ctrl_i[C_LONG];
      frame_q <= new_frame;
      cnt_q   <= '0;
      tmo_q   <= '0;
      cmd_q   <= 1'b1;
      oe_q    <= 1'b0;
      if (!ctrl_i[C_EN])      st_q <= S_IDLE;
      else if (ctrl_i[C_HOLD]) st_q <= S_HOLD;
      else                     st_q <= S_TX;
    end else if (card_tick_i) begin
      unique case (st_q)
        S_TX: begin
          cmd_q   <= frame_q[FRAME_W-1];
          oe_q    <= 1'b1;
          frame_q <= frame_q << 1;
          if (cnt_q == CNT_W'(FRAME_W - 1)) begin
            st_q  <= S_TX_END;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_TX_END: begin
          cmd_q <= 1'b1;
          oe_q  <= 1'b0;
          tmo_q <= '0;
          st_q  <= rsp_q ? S_RX_WAIT : S_IDLE;
        end
        S_RX_WAIT: begin
          if (!cmd_i) begin
            st_q  <= S_RX;
            cnt_q <= CNT_W'(1);
          end else if (tmo_q == TMO_W'(TMO_TICKS - 1)) begin
            st_q <= S_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        S_RX: begin
          if (rx_last) st_q <= S_IDLE;
          else         cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  cmd_crc7_ser u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (crc_clr),
    .en_i    (crc_en),
    .bit_i   (cmd_i),
    .crc_o   (crc_calc)
  );

  cmd_rsp_capture #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (cap_shift),
    .bit_i      (cmd_i),
    .ld_short_i (ld_s),
    .ld_long_i  (ld_l),
    .crc_rx_o   (crc_rx),
    .words_o    (words)
  );

  cmd_status_regs #(.N(NSTAT), .CLR_W(CLR_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ev_set),
    .clr_we_i (clr_we_i),
    .clr_i    (clr_i),
    .status_o (status_o)
  );

  assign cmd_o    = cmd_q;
  assign cmd_oe_o = oe_q;
  assign busy_o   = (st_q != S_IDLE);
  assign rsp0_o   = words[0];
  assign rsp1_o   = words[1];
  assign rsp2_o   = words[2];
  assign rsp3_o   = words[3];

  p_drive_only_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_oe_o |-> busy_o);
  p_abort_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_i[C_EN]) |=> (!busy_o && !cmd_oe_o));
  p_abort_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ((status_o & ~$past(status_o)) == '0));
  p_hold_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_i[C_EN] && ctrl_i[C_HOLD]) |=> (busy_o && !cmd_oe_o));
endmodule

// File: tb/cmd_path_bench.sv
module cmd_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        arg_we = 1'b0;
  logic [31:0] arg = '0;
  logic        ctrl_we = 1'b0;
  logic [9:0]  ctrl = '0;
  logic        clr_we = 1'b0;
  logic [11:0] clr = '0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe, busy;
  logic [3:0]  status;
  logic [31:0] r0, r1, r2, r3;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [127:0] exp_words = '0;

  always #5 clk = ~clk;

  cmd_path u_cmd_path (
    .clk_i(clk), .rst_ni(rst_n), .card_tick_i(tick),
    .arg_we_i(arg_we), .arg_i(arg), .ctrl_we_i(ctrl_we), .ctrl_i(ctrl),
    .clr_we_i(clr_we), .clr_i(clr), .cmd_i(cmd_in),
    .cmd_o(cmd_out), .cmd_oe_o(cmd_oe), .busy_o(busy), .status_o(status),
    .rsp0_o(r0), .rsp1_o(r1), .rsp2_o(r2), .rsp3_o(r3)
  );

  // {index, arg, mode(0 none,1 short,2 long), delay, corrupt, payload}
  localparam logic [79:0] VEC [9] = '{
    {6'd0,  32'h0000_0000, 2'd0, 7'd0,  1'b0, 32'h0000_0000},
    {6'd8,  32'h0000_01AA, 2'd1, 7'd2,  1'b0, 32'h0000_01AA},
    {6'd55, 32'h0000_0000, 2'd1, 7'd0,  1'b0, 32'h0000_0120},
    {6'd41, 32'h40FF_8000, 2'd1, 7'd5,  1'b1, 32'h80FF_8000},
    {6'd2,  32'h0000_0000, 2'd2, 7'd3,  1'b0, 32'hDEAD_BEEF},
    {6'd9,  32'h1234_0000, 2'd2, 7'd63, 1'b1, 32'h1234_5678},
    {6'd13, 32'h0001_0000, 2'd1, 7'd64, 1'b0, 32'h0000_0900},
    {6'd17, 32'hFFFF_FFFF, 2'd1, 7'd63, 1'b0, 32'h0000_0000},
    {6'd63, 32'hA5A5_A5A5, 2'd0, 7'd0,  1'b0, 32'h0000_0000}
  };

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] r;
    logic f;
    r = '0;
    for (int i = 39; i >= 0; i--) begin
      f = d[i] ^ r[6];
      r = {r[5:0], 1'b0};
      if (f) r = r ^ 7'h09;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic card_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_arg(input logic [31:0] v);
    @(negedge clk); arg_we = 1'b1; arg = v;
    @(negedge clk); arg_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [9:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_clr(input logic [11:0] v);
    @(negedge clk); clr_we = 1'b1; clr = v;
    @(negedge clk); clr_we = 1'b0;
  endtask

  task automatic run_vec(input logic [79:0] v);
    logic [5:0]   opc;
    logic [31:0]  a, pay;
    logic [1:0]   mode;
    logic [6:0]   dly;
    logic         bad;
    logic [47:0]  fr, got;
    logic [135:0] rep;
    logic [127:0] lb;
    logic [3:0]   exp_st;
    int           len;
    bit           ok;
    {opc, a, mode, dly, bad, pay} = v;
    fr = {2'b01, opc, a, ref_crc({2'b01, opc, a}), 1'b1};
    wr_arg(a);
    wr_ctrl({1'b1, 1'b0, mode == 2'd2, mode != 2'd0, opc});
    ok = 1'b1;
    got = '0;
    for (int i = 0; i < 48; i++) begin
      card_tick();
      got[47-i] = cmd_out;
      if (!cmd_oe || cmd_out !== fr[47-i]) ok = 1'b0;
    end
    chk(ok, "R2 frame bits", {80'd0, got}, {80'd0, fr});
    card_tick();
    chk(!cmd_oe && cmd_out, "R3 line released after frame", {126'd0, cmd_oe, cmd_out}, 128'd1);
    if (mode == 2'd0) begin
      exp_st = 4'b0001;  // R3 sent
    end else begin
      cmd_in = 1'b1;
      for (int i = 0; i < ((dly >= 7'd64) ? 64 : int'(dly)); i++) card_tick();
      if (dly >= 7'd64) begin
        exp_st = 4'b1000;  // R7 timeout
      end else begin
        if (mode == 2'd1) begin
          len = 48;
          rep = '0;
          rep[47:0] = {2'b00, opc, pay, ref_crc({2'b00, opc, pay}) ^ {6'd0, bad}, 1'b1};
          exp_st = bad ? 4'b0100 : 4'b0010;  // R5 / R4
          exp_words = {96'd0, pay};
        end else begin
          len = 136;
          lb = {pay, ~pay, pay ^ 32'h5A5A_5A5A, a};
          rep = {2'b00, 6'h3F, lb[127:1], 1'b1};
          exp_st = 4'b0010;  // R6
          exp_words = {lb[127:1], 1'b0};
        end
        for (int i = 0; i < len; i++) begin
          cmd_in = rep[len-1-i];
          card_tick();
        end
        cmd_in = 1'b1;
      end
    end
    chk(status == exp_st, "R3/R4/R5/R6/R7 status", {124'd0, status}, {124'd0, exp_st});
    chk({r3, r2, r1, r0} == exp_words, "R4/R6 response words", {r3, r2, r1, r0}, exp_words);
    chk(!busy, "R3 idle after command", {127'd0, busy}, 128'd0);
    wr_clr(12'hFFF);
    chk(status == 4'd0, "R10 clear all", {124'd0, status}, 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !cmd_oe && cmd_out && status == 4'd0, "R1 reset outputs",
        {123'd0, busy, cmd_oe, cmd_out, status[1:0]}, {125'd0, 3'b010});
    chk({r3, r2, r1, r0} == 128'd0, "R1 reset words", {r3, r2, r1, r0}, 128'd0);

    for (int k = 0; k < 9; k++) run_vec(VEC[k]);

    // R8 abort mid frame
    wr_arg(32'h0BAD_F00D);
    wr_ctrl({4'b1001, 6'd17});
    repeat (10) card_tick();
    wr_ctrl(10'd0);
    chk(!busy && !cmd_oe, "R8 abort releases", {126'd0, busy, cmd_oe}, 128'd0);
    ok = 1'b1;
    for (int i = 0; i < 50; i++) begin
      card_tick();
      if (cmd_oe) ok = 1'b0;
    end
    chk(ok && status == 4'd0, "R8 no status after abort", {124'd0, status}, 128'd0);

    // R9 hold bit
    wr_ctrl({4'b1100, 6'd3});
    ok = 1'b1;
    for (int i = 0; i < 60; i++) begin
      card_tick();
      if (cmd_oe || !busy) ok = 1'b0;
    end
    chk(ok, "R9 hold stays busy without driving", {126'd0, busy, cmd_oe}, {126'd0, 2'b10});
    wr_ctrl(10'd0);
    chk(!busy && status == 4'd0, "R8 abort from hold", {123'd0, busy, status}, 128'd0);

    // R10 partial clear
    wr_ctrl({4'b1000, 6'd5});
    repeat (49) card_tick();
    chk(status == 4'b0001, "R3 sent flag", {124'd0, status}, 128'd1);
    wr_clr(12'hFFE);
    chk(status == 4'b0001, "R10 zero mask bit keeps flag", {124'd0, status}, 128'd1);
    wr_clr(12'h001);
    chk(status == 4'b0000, "R10 one clears flag", {124'd0, status}, 128'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule